// File: doc/BRIEF.md
# Configurable Boolean Crossbar Switch

This block is a routing-matrix switch for pattern-matching engines. It keeps an R-row by C-column matrix of single-bit cells. For each row it also keeps one acceptance cell. The block runs in one of two modes, and the write-enable input picks the mode on every cycle.

In configuration mode one row is written per cycle. The write covers a single chunk of W adjacent columns, picked by a chunk index, and every other cell keeps its value. In operational mode an R-bit vector drives all rows at once. Output column j is set when some row has both its input bit and its cell in column j at 1. The same OR over rows is taken across the acceptance cells, and it gives an acceptance flag in the same evaluation. The result is registered. Typical uses are as a local switch, a global switch or a symbol-match array; each is one instance with different R, C and W.

Top module: `bool_xbar`

## Requirements
- R1: After reset every matrix cell and every acceptance cell is 0, and out_vec and out_acc are 0. Any input vector applied before the first write therefore gives all-zero outputs.
- R2: While cfg_we is 1 (configuration mode), out_vec and out_acc keep the values they had before that cycle.
- R3: While cfg_we is 0 (operational mode), out_vec[j] one clock after in_vec is applied equals the OR over rows i of (in_vec[i] AND cell[i][j]).
- R4: Any number of in_vec bits may be 1 in the same cycle. The hits of all active rows are ORed per column.
- R5: A configuration cycle with cfg_row below R writes chunk k = cfg_chunk of that row. cfg_data bit b goes to column k*W+b; a 1 sets the cell and a 0 clears it. The new contents are used from the next operational evaluation.
- R6: A configuration write leaves every cell outside the selected chunk unchanged, both in the addressed row and in all other rows.
- R7: A configuration cycle with cfg_row equal to or greater than R changes no cell.
- R8: A configuration cycle with cfg_acc_wr at 1 loads cfg_acc_val into the addressed row's acceptance cell; with cfg_acc_wr at 0 that cell is left unchanged. In operational mode out_acc, one clock after in_vec is applied, is the OR over rows of (in_vec[i] AND acceptance cell[i]).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | 1 = configuration mode, 0 = operational mode |
| cfg_row | input | clog2(R) | Row address of the configuration write |
| cfg_chunk | input | clog2(C/W) | Index of the column chunk to write |
| cfg_data | input | W | Cell values for the selected chunk |
| cfg_acc_wr | input | 1 | Also write the row's acceptance cell |
| cfg_acc_val | input | 1 | Value for the acceptance cell |
| in_vec | input | R | Row activation vector |
| out_vec | output | C | Registered column results |
| out_acc | output | 1 | Registered acceptance flag |

## Verification
The bench writes to chunks that border each other and then rewrites a neighbouring chunk of the same row. A design that writes the full row width, or that decodes the chunk index wrongly, would corrupt columns that were written earlier. It also writes to row addresses past the last row; a design that aliases those addresses would overwrite a real row. Activation vectors with many rows set, a zero vector, and configuration cycles placed between evaluations are used to catch three faults: AND-combining of rows, an output register that updates during configuration, and an acceptance cell that changes when its strobe is 0.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
package xbar_pkg;
    typedef enum logic {
        XB_RUN = 1'b0,
        XB_CFG = 1'b1
    } xb_mode_e;
endpackage

// File: rtl/xbar_row.sv
`timescale 1ns/1ps
module xbar_row #(
    parameter int C   = 32,
    parameter int W   = 8,
    parameter int CW  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [CW-1:0] chunk,
    input  logic [W-1:0] data,
    input  logic         acc_wr,
    input  logic         acc_val,
    output logic [C-1:0] bits_o,
    output logic         acc_o
);
    localparam int NCH = C / W;

    typedef struct packed {
        logic [C-1:0] bits;
        logic         acc;
    } row_t;

    row_t         row_d, row_q;
    logic [C-1:0] bits_nx;

    for (genvar k = 0; k < NCH; k++) begin : g_chunk
        assign bits_nx[k*W +: W] = (wr_en && chunk == CW'(k)) ? data : row_q.bits[k*W +: W];

        // R6
        untouched_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en || chunk != CW'(k)) |=> $stable(row_q.bits[k*W +: W]));

        // R5
        chunk_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && chunk == CW'(k)) |=> (row_q.bits[k*W +: W] == $past(data)));
    end

    always_comb begin
        row_d      = row_q;
        row_d.bits = bits_nx;
        if (wr_en && acc_wr) begin
            row_d.acc = acc_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else begin
            row_q <= row_d;
        end
    end

    assign bits_o = row_q.bits;
    assign acc_o  = row_q.acc;

    // R8
    acc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && acc_wr) |=> $stable(acc_o));
endmodule

// File: rtl/xbar_colsum.sv
`timescale 1ns/1ps
module xbar_colsum #(
    parameter int R = 12,
    parameter int C = 32
) (
    input  logic [R-1:0] in_vec,
    input  logic [C-1:0] mat [R],
    input  logic [R-1:0] acc_col,
    output logic [C-1:0] col_o,
    output logic         acc_o
);
    for (genvar j = 0; j < C; j++) begin : g_col
        logic [R-1:0] hit;
        for (genvar i = 0; i < R; i++) begin : g_row
            assign hit[i] = in_vec[i] & mat[i][j];
        end
        assign col_o[j] = |hit;
    end

    assign acc_o = |(in_vec & acc_col);
endmodule

// File: rtl/bool_xbar.sv
`timescale 1ns/1ps
module bool_xbar
    import xbar_pkg::*;
#(
    parameter int R = 12,
    parameter int C = 32,
    parameter int W = 8,
    localparam int NCH = C / W,
    localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int RW  = (R > 1) ? $clog2(R) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [RW-1:0] cfg_row,
    input  logic [CW-1:0] cfg_chunk,
    input  logic [W-1:0]  cfg_data,
    input  logic          cfg_acc_wr,
    input  logic          cfg_acc_val,
    input  logic [R-1:0]  in_vec,
    output logic [C-1:0]  out_vec,
    output logic          out_acc
);
    typedef struct packed {
        logic [C-1:0] out;
        logic         acc;
    } obs_t;

    xb_mode_e     mode;
    logic [R-1:0] row_wr;
    logic [C-1:0] mat [R];
    logic [R-1:0] acc_col;
    logic [C-1:0] col_sum;
    logic         acc_sum;
    obs_t         obs_d, obs_q;

    assign mode = xb_mode_e'(cfg_we);

    for (genvar i = 0; i < R; i++) begin : g_row
        assign row_wr[i] = (mode == XB_CFG) && (cfg_row == RW'(i));

        xbar_row #(.C(C), .W(W), .CW(CW)) row_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (row_wr[i]),
            .chunk   (cfg_chunk),
            .data    (cfg_data),
            .acc_wr  (cfg_acc_wr),
            .acc_val (cfg_acc_val),
            .bits_o  (mat[i]),
            .acc_o   (acc_col[i])
        );
    end

    xbar_colsum #(.R(R), .C(C)) colsum_i (
        .in_vec  (in_vec),
        .mat     (mat),
        .acc_col (acc_col),
        .col_o   (col_sum),
        .acc_o   (acc_sum)
    );

    always_comb begin
        obs_d = obs_q;
        if (mode == XB_RUN) begin
            obs_d.out = col_sum;
            obs_d.acc = acc_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obs_q <= '0;
        end else begin
            obs_q <= obs_d;
        end
    end

    assign out_vec = obs_q.out;
    assign out_acc = obs_q.acc;

    // R2
    hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> ($stable(out_vec) && $stable(out_acc)));

    // R3
    zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && in_vec == '0) |=> (out_vec == '0 && !out_acc));

    // R7
    oob_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg_row) >= R) |-> (row_wr == '0));

    // R7
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_wr));
endmodule

// File: tb/bool_xbar_tb.sv
`timescale 1ns/1ps
module bool_xbar_tb_top;
    localparam int R   = 12;
    localparam int C   = 32;
    localparam int W   = 8;
    localparam int NCH = C / W;
    localparam int CW  = 2;
    localparam int RW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [RW-1:0] cfg_row = '0;
    logic [CW-1:0] cfg_chunk = '0;
    logic [W-1:0]  cfg_data = '0;
    logic          cfg_acc_wr = 1'b0;
    logic          cfg_acc_val = 1'b0;
    logic [R-1:0]  in_vec = '0;
    logic [C-1:0]  out_vec;
    logic          out_acc;

    bit           mdl [R][C];
    bit           mdl_acc [R];
    logic [C-1:0] exp_out = '0;
    logic         exp_acc = 1'b0;
    int           total = 0;
    int           fails = 0;
    logic [31:0]  lfsr = 32'hACE1_2468;

    always #5 clk = ~clk;

    bool_xbar #(.R(R), .C(C), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row),
        .cfg_chunk(cfg_chunk), .cfg_data(cfg_data), .cfg_acc_wr(cfg_acc_wr),
        .cfg_acc_val(cfg_acc_val), .in_vec(in_vec), .out_vec(out_vec), .out_acc(out_acc)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(input string tag);
        total++;
        if (out_vec !== exp_out || out_acc !== exp_acc) begin
            fails++;
            $display("FAIL %s: got out=%h acc=%b, expected out=%h acc=%b",
                     tag, out_vec, out_acc, exp_out, exp_acc);
        end
    endtask

    // Advance the reference by one clock using the inputs now applied, then compare.
    task automatic step(input string tag);
        if (cfg_we) begin
            if (int'(cfg_row) < R) begin
                for (int b = 0; b < W; b++) mdl[cfg_row][int'(cfg_chunk)*W + b] = cfg_data[b];
                if (cfg_acc_wr) mdl_acc[cfg_row] = cfg_acc_val;
            end
        end else begin
            exp_out = '0;
            exp_acc = 1'b0;
            for (int i = 0; i < R; i++) begin
                if (in_vec[i]) begin
                    for (int j = 0; j < C; j++) if (mdl[i][j]) exp_out[j] = 1'b1;
                    if (mdl_acc[i]) exp_acc = 1'b1;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic wr(input int row, input int ch, input logic [W-1:0] d,
                      input logic aw, input logic av, input string tag);
        cfg_we = 1'b1; cfg_row = RW'(row); cfg_chunk = CW'(ch); cfg_data = d;
        cfg_acc_wr = aw; cfg_acc_val = av;
        step(tag);
    endtask

    task automatic run(input logic [R-1:0] v, input string tag);
        cfg_we = 1'b0; cfg_acc_wr = 1'b0; in_vec = v;
        step(tag);
    endtask

    initial begin
        #1_000_000;
        fails++;
        total++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset outputs");
        run('1, "R1 empty matrix");
        run(12'h5A5, "R1 empty matrix");

        wr(0, 0, 8'hA5, 1'b0, 1'b0, "R5 write");
        wr(0, 1, 8'h3C, 1'b0, 1'b0, "R5 write");
        wr(3, 2, 8'hFF, 1'b0, 1'b0, "R5 write");
        wr(11, 3, 8'h81, 1'b0, 1'b0, "R5 last row");
        run(12'h001, "R3 single row");
        run(12'h008, "R3 single row");
        run(12'h800, "R3 last row");
        run(12'h809, "R4 many rows");
        run('1, "R4 all rows");

        wr(0, 1, 8'h00, 1'b0, 1'b0, "R2 hold during cfg");
        run(12'h001, "R6 neighbour chunk kept");
        wr(0, 0, 8'h0F, 1'b0, 1'b0, "R2 hold during cfg");
        run(12'h001, "R5 clear bits");
        wr(3, 1, 8'h42, 1'b0, 1'b0, "R2 hold during cfg");
        run(12'h008, "R6 row3 chunk2 kept");

        wr(12, 0, 8'hFF, 1'b1, 1'b1, "R7 oob write");
        wr(15, 3, 8'hFF, 1'b1, 1'b1, "R7 oob write");
        run('1, "R7 oob ignored");

        wr(2, 0, 8'h00, 1'b1, 1'b1, "R8 acc write");
        run(12'h004, "R8 acc set");
        run(12'h020, "R8 acc other row");
        wr(2, 3, 8'h10, 1'b0, 1'b0, "R8 acc no strobe");
        run(12'h004, "R8 acc kept");
        wr(2, 2, 8'h00, 1'b1, 1'b0, "R8 acc clear");
        run(12'h004, "R8 acc cleared");
        run('0, "R3 zero input");

        for (int n = 0; n < 300; n++) begin
            lfsr = next_rand(lfsr);
            if (lfsr[0]) begin
                wr(int'(lfsr[4:1]), int'(lfsr[6:5]), lfsr[14:7], lfsr[15], lfsr[16], "R5 mixed write");
            end else begin
                run(lfsr[27:16] & lfsr[11:0], "R4 mixed run");
            end
        end
        run('1, "R4 final sweep");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule